// File: doc/BRIEF.md
# Period-Match Interval Timer

This block is an 8-bit interval timer. It counts up on a quarter-rate tick taken from the system clock, after a selectable prescale of 1, 4 or 16. When the count equals a programmable period value at an increment, the count returns to zero and a one-clock match pulse is produced. Software can pick a 1-to-16 postscale, and after that many matches a sticky interrupt flag is set.

Software reaches the count, the period, the control byte and the flag through a small register bus with four addresses. Any register can be written in one cycle. A read returns the addressed register one clock after the address is presented. The match pulse is brought out on its own pin so that a serial block can use it as a baud tick.

Top module: `period_timer`

## Requirements
- R1: After reset the count reads 0x00, the period reads 0xFF, the control byte reads 0x00, the flag reads 0 and `match_tick` is low.
- R2: The addresses are 0 count, 1 period, 2 control and 3 flag (data bit 0). `bus_rdata` shows the addressed register one clock after the address is applied. Control bit 7 always reads 0.
- R3: The base tick occurs once every 4 system clocks. While the timer runs, the count advances once per base tick multiplied by the prescale.
- R4: Control bits 1:0 select the prescale: 00 gives 1, 01 gives 4, and 10 or 11 give 16.
- R5: When an increment finds the count equal to the period, the count becomes 0 and `match_tick` is high for exactly one clock. In steady state matches are (period+1) × prescale × 4 clocks apart.
- R6: Control bits 6:3 hold a value n. The flag is set on every (n+1)-th match, so in steady state successive flag sets are (period+1) × prescale × (n+1) × 4 clocks apart.
- R7: Control bit 2 enables counting. While it is 0 the count keeps its value.
- R8: Once set, the flag stays set until a bus write puts 0 in it. If a set and a clearing write fall in the same clock, the flag ends up set.
- R9: A write to the count or to the control byte clears the prescale and postscale progress. A count write takes priority over an increment in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| match_tick | output | 1 | One-clock pulse on each period match |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
Both match spacing and flag spacing are measured in clocks for several period, prescale and postscale settings, some directed and some random. These include period 0, the two codes that select divide-by-16, and a full 0xFF period. A mismatch in these intervals separates a wrong prescale decode from an off-by-one in the period compare or in the postscale count. Directed sequences also do three things: they hold the count with the timer off, they place a clearing write on the exact clock a flag set occurs and then one clock later, and they rewrite the count after the prescaler has partly filled, which shows whether the scaler progress was discarded.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int DATA_W = 8;
  localparam int PRE_W  = 4;
  localparam int POST_W = 4;

  typedef enum logic [1:0] {
    ADDR_COUNT  = 2'd0,
    ADDR_PERIOD = 2'd1,
    ADDR_CTRL   = 2'd2,
    ADDR_FLAG   = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic              spare;
    logic [POST_W-1:0] post_sel;
    logic              run;
    logic [1:0]        pre_sel;
  } ctrl_t;

  function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] sel);
    case (sel)
      2'b00:   pre_limit = PRE_W'(0);
      2'b01:   pre_limit = PRE_W'(3);
      default: pre_limit = PRE_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  logic [W-1:0] phase_q;

  assign tick = (phase_q == W'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || tick) phase_q <= '0;
    else             phase_q <= phase_q + 1'b1;
  end

  assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/prescaler.sv
module prescaler
  import timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr,
  input  logic       en,
  input  logic [1:0] sel,
  output logic       pre_tick
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] lim;

  assign lim      = pre_limit(sel);
  assign pre_tick = en && (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (en)    cnt_q <= pre_tick ? '0 : cnt_q + 1'b1;
  end

  assert_pre_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= lim);
endmodule

// File: rtl/period_counter.sv
module period_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic [W-1:0] period,
  output logic [W-1:0] cnt,
  output logic         hit
);
  logic [W-1:0] cnt_q;

  assign cnt = cnt_q;
  assign hit = inc && !wr_en && (cnt_q == period);

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (wr_en) cnt_q <= wr_data;
    else if (inc)   cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> cnt_q == $past(wr_data));
  assert_wrap_zero_R5: assert property (@(posedge clk) disable iff (rst)
    hit |=> cnt_q == '0);
  assert_hold_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!inc && !wr_en) |=> $stable(cnt_q));
endmodule

// File: rtl/postscaler.sv
module postscaler #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         evt,
  input  logic [W-1:0] sel,
  output logic         fire
);
  logic [W-1:0] cnt_q;

  assign fire = evt && (cnt_q == sel);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (evt)   cnt_q <= fire ? '0 : cnt_q + 1'b1;
  end

  assert_post_bound_R6: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= sel);
endmodule

// File: rtl/period_timer.sv
module period_timer
  import timer_pkg::*;
#(
  parameter int TICK_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              match_tick,
  output logic              irq_flag
);
  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] period_q;
  logic [DATA_W-1:0] count;
  logic [DATA_W-1:0] rdata_q;
  logic              flag_q;
  logic              match_q;
  logic              base_tick;
  logic              pre_tick;
  logic              hit;
  logic              fire;
  logic              wr_count, wr_period, wr_ctrl, wr_flag, scaler_clr;

  assign wr_count   = bus_wr && (bus_addr == ADDR_COUNT);
  assign wr_period  = bus_wr && (bus_addr == ADDR_PERIOD);
  assign wr_ctrl    = bus_wr && (bus_addr == ADDR_CTRL);
  assign wr_flag    = bus_wr && (bus_addr == ADDR_FLAG);
  assign scaler_clr = wr_count || wr_ctrl;

  tick_divider #(.DIV(TICK_DIV)) u_div (
    .clk(clk), .rst(rst), .tick(base_tick));

  prescaler u_pre (
    .clk(clk), .rst(rst), .clr(scaler_clr),
    .en(base_tick && ctrl_q.run), .sel(ctrl_q.pre_sel), .pre_tick(pre_tick));

  period_counter #(.W(DATA_W)) u_cnt (
    .clk(clk), .rst(rst), .inc(pre_tick), .wr_en(wr_count),
    .wr_data(bus_wdata), .period(period_q), .cnt(count), .hit(hit));

  postscaler #(.W(POST_W)) u_post (
    .clk(clk), .rst(rst), .clr(scaler_clr), .evt(hit),
    .sel(ctrl_q.post_sel), .fire(fire));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      period_q <= '1;
      flag_q   <= 1'b0;
      match_q  <= 1'b0;
    end else begin
      if (wr_ctrl)   ctrl_q   <= {1'b0, bus_wdata[6:0]};
      if (wr_period) period_q <= bus_wdata;
      if (fire)         flag_q <= 1'b1;
      else if (wr_flag) flag_q <= bus_wdata[0];
      match_q <= hit;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else begin
      case (bus_addr)
        ADDR_COUNT:  rdata_q <= count;
        ADDR_PERIOD: rdata_q <= period_q;
        ADDR_CTRL:   rdata_q <= ctrl_q;
        default:     rdata_q <= {{(DATA_W-1){1'b0}}, flag_q};
      endcase
    end
  end

  assign bus_rdata  = rdata_q;
  assign match_tick = match_q;
  assign irq_flag   = flag_q;

  assert_match_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    match_q |=> !match_q);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    fire |=> flag_q);
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !wr_flag) |=> flag_q);
  assert_spare_zero_R2: assert property (@(posedge clk) disable iff (rst)
    !ctrl_q.spare);
endmodule

// File: tb/period_timer_test.sv
module period_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       match_tick, irq_flag;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [7:0] rv;

  period_timer uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .match_tick(match_tick), .irq_flag(irq_flag));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int pre_ratio(input int sel);
    if (sel == 0) return 1;
    if (sel == 1) return 4;
    return 16;
  endfunction

  function automatic int flag_interval(input int pr, input int psel, input int post);
    return (pr + 1) * pre_ratio(psel) * (post + 1) * 4;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_tick();
    while (!match_tick) @(negedge clk);
  endtask

  task automatic measure(input int pr, input int psel, input int post);
    int t1, t2;
    wr(2'd2, 8'h00);
    wr(2'd1, 8'(pr));
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h00);
    wr(2'd2, {1'b0, 4'(post), 1'b1, 2'(psel)});
    while (!irq_flag) @(negedge clk);
    t1 = cyc;
    wr(2'd3, 8'h00);
    while (!irq_flag) @(negedge clk);
    t2 = cyc;
    // R6: flag spacing
    check("R6 flag interval", t2 - t1, flag_interval(pr, psel, post));
    wait_tick();
    t1 = cyc;
    @(negedge clk);
    wait_tick();
    t2 = cyc;
    // R3 R4 R5: match spacing
    check("R5 match interval", t2 - t1, (pr + 1) * pre_ratio(psel) * 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    check("R1 match_tick", match_tick, 0);
    check("R1 flag pin", irq_flag, 0);
    rd(2'd0, rv); check("R1 count", rv, 8'h00);
    rd(2'd1, rv); check("R1 period", rv, 8'hFF);
    rd(2'd2, rv); check("R1 ctrl", rv, 8'h00);
    rd(2'd3, rv); check("R1 flag", rv, 0);

    // R2: register access, control bit 7 reads 0
    wr(2'd1, 8'h37); rd(2'd1, rv); check("R2 period rw", rv, 8'h37);
    wr(2'd2, 8'hF8); rd(2'd2, rv); check("R2 ctrl bit7", rv, 8'h78);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h12); rd(2'd0, rv); check("R2 count rw", rv, 8'h12);

    // R7: stopped timer holds the count
    repeat (200) @(negedge clk);
    rd(2'd0, rv); check("R7 hold when off", rv, 8'h12);

    // R9: count write clears partial prescale progress
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h06);
    repeat (37) @(negedge clk);
    wr(2'd0, 8'h40);
    repeat (50) @(negedge clk);
    rd(2'd0, rv); check("R9 prescaler cleared", rv, 8'h40);

    // R8: clear colliding with a set leaves flag set; clear alone clears
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h04);
    @(negedge clk);
    wait_tick();
    repeat (3) @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 8'h00;
    @(negedge clk);
    check("R8 set wins over clear", irq_flag, 1);
    @(negedge clk);
    bus_wr = 1'b0;
    check("R8 clear by write", irq_flag, 0);
    @(negedge clk);
    check("R8 stays clear", irq_flag, 0);

    // R3 R4 R5 R6: directed intervals
    measure(0, 0, 0);
    measure(3, 3, 0);
    measure(2, 2, 1);
    measure(5, 1, 2);
    measure(255, 0, 0);
    measure(1, 0, 15);

    // random intervals
    for (int i = 0; i < 6; i++) begin
      measure(int'($urandom % 16), int'($urandom % 4), int'($urandom % 8));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule